// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel NOR-style flash device. Bus write cycles, made of two active-low chip enables, an active-low write enable, an address and a data byte, reach a decoder. The decoder chooses what a read returns: array data, identifier codes, a small query table or the status register. It also runs the two-write protected sequences for program, block erase and lock-bit configuration. An abstract cycle counter stands in for the internal program and erase algorithm. An erase in progress can be suspended so that other locations can be read or programmed. A program in progress can be suspended so that other locations can be read. A resume command restarts the most recently suspended operation from where it stopped. A small behavioural array with one lock bit per block holds the contents.

Array changes take effect only when an operation completes. A low reset/power-down input therefore aborts a running operation and leaves the contents as they were. The programming-voltage-valid input is checked at completion; when it is false the contents stay as they were and an error is reported. The write port is a plain strobe with no back-pressure, and writes that arrive during a busy period are dropped, except for the two commands listed in R13. The read port is combinational and has an explicit output-enable pin in place of high-Z drivers.

Top module: `fci_top`

## Requirements
- R1: While `rp_n` is low, `ready` is low, `dq_en` is low, writes are ignored and any running or pending operation is abandoned with no change to array contents. After `rp_n` returns high, or after `rst_n`, the read mode is array and the status register reads 0x80.
- R2: `dq_en` is high only when `rp_n`, `we_n` and all three active-low selects are in their read state (`ce0_n`, `ce1_n` and `oe_n` all low). While either chip enable is high, `dq_en` is low regardless of `oe_n`.
- R3: Command 0xFF selects array reads.
- R4: Command 0x90 selects identifier reads, keyed on address bits [1:0]: 0 gives `MFR_ID` (default 0xA5), 1 gives `DEV_ID` (default 0x3C), and 2 gives the lock bit of the addressed block in bit 0. Command 0x98 selects query reads: offsets 0, 1 and 2 give 0x51, 0x52 and 0x59, and every other offset gives 0. None of these reads depends on `vpp_ok`.
- R5: Command 0x70 selects status reads. Status bit 7 means ready, bit 6 erase suspended, bit 5 erase/lock error, bit 4 program/lock error, bit 3 low programming voltage, bit 2 program suspended, bit 1 locked-block error and bit 0 is always 0. Command 0x50 clears bits 5, 4, 3 and 1.
- R6: Writing 0x40 and then data D at address A programs A to (old AND D), taking `PROG_CYC` cycles. `ready` is low from the cycle after the data write for exactly `PROG_CYC` cycles. Any setup write selects status reads.
- R7: Writing 0x20 and then 0xD0 at any address of a block erases the whole block to 0xFF, taking `ERASE_CYC` cycles. The block number is the top `BLK_W` address bits.
- R8: An erase setup followed by any byte other than 0xD0, or a lock setup followed by a byte other than 0x01 or 0xD0, starts nothing. It sets status bits 5 and 4 and selects status reads.
- R9: If `vpp_ok` is low when an operation completes, the contents and lock bits stay as they were, and bit 3 is set together with bit 4 (program), bit 5 (erase) or bits 4 and 5 (lock configuration).
- R10: Writing 0x60 then 0x01 sets the lock bit of the addressed block, and 0x60 then 0xD0 clears all lock bits; each takes `ERASE_CYC` cycles. A program or erase that targets a locked block changes nothing and sets bit 1 together with bit 4 (program) or bit 5 (erase).
- R11: Writing 0xB0 during an erase makes `ready` high on the next cycle, sets bit 6 and freezes the erase counter. Array reads and programming of other locations are then allowed. 0xD0 resumes the erase, which then runs only its remaining cycles.
- R12: Writing 0xB0 during a program sets bit 2 and freezes that program. When both operations are suspended, 0xD0 resumes the program first and the next 0xD0 resumes the erase.
- R13: While an operation runs, only 0x70 and 0xB0 are accepted and every other write is ignored. Deasserting the chip enables does not stop the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rp_n | input | 1 | Reset/power-down, active low, sampled on the clock |
| vpp_ok | input | 1 | Programming voltage valid |
| ce0_n | input | 1 | Chip enable 0, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; one write per clock while active |
| addr | input | ADDR_W | Word address |
| wdata | input | 8 | Write data or command byte |
| dq_out | output | 8 | Read data, zero when not enabled |
| dq_en | output | 1 | Output drivers enabled |
| ready | output | 1 | High when no operation runs and `rp_n` is high |

## Verification
A write is captured at the clock edge where it is active. Mode and status therefore change after that edge, and the combinational read path shows them one time step after the inputs change at the following falling edge. The bench samples reads there. `ready` goes low after the edge that takes a confirm or data write, so the bench checks it at the next falling edge. It checks again `PROG_CYC`-1 or `ERASE_CYC`-1 falling edges later, when `ready` must still be low, and once more one edge after that, when it must be high. For suspend and resume, the bench counts the falling edges spent busy after a resume and compares them with the full duration minus the cycles already run before the suspend. For a suspend written k edges after the confirm, the cycles already run are k plus one.

// File: rtl/fci_pkg.sv
package fci_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] C_ARRAY   = 8'hFF;
  localparam logic [DW-1:0] C_IDENT   = 8'h90;
  localparam logic [DW-1:0] C_QUERY   = 8'h98;
  localparam logic [DW-1:0] C_STATUS  = 8'h70;
  localparam logic [DW-1:0] C_CLEAR   = 8'h50;
  localparam logic [DW-1:0] C_ERASE   = 8'h20;
  localparam logic [DW-1:0] C_PROG    = 8'h40;
  localparam logic [DW-1:0] C_LOCK    = 8'h60;
  localparam logic [DW-1:0] C_LOCKSET = 8'h01;
  localparam logic [DW-1:0] C_CONFIRM = 8'hD0;
  localparam logic [DW-1:0] C_SUSP    = 8'hB0;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_QUERY, RM_STATUS} rmode_t;
  typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG, PD_LOCK} pend_t;
  typedef enum logic [1:0] {EK_ERASE, EK_LOCKSET, EK_LOCKCLR} ekind_t;
endpackage

// File: rtl/fci_timer.sv
module fci_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  logic [CW-1:0] cnt;

  assign done = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (done)   cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  // R11: the frozen count of a suspended operation never passes its limit
  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));
endmodule

// File: rtl/fci_array.sv
module fci_array #(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_en,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  logic              erase_en,
  input  logic              lock_set,
  input  logic              lock_clr,
  input  logic [BLK_W-1:0]  op_blk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic [(1<<BLK_W)-1:0] lock_bits
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WPB   = 1 << (ADDR_W - BLK_W);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (prog_en) mem[prog_addr] <= mem[prog_addr] & prog_data;
    if (erase_en)
      for (int i = 0; i < DEPTH; i++)
        if ((i / WPB) == int'(op_blk)) mem[i] <= 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_bits <= '0;
    else if (lock_clr) lock_bits <= '0;
    else if (lock_set) lock_bits[op_blk] <= 1'b1;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fci_ctrl.sv
module fci_ctrl
  import fci_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              vpp_ok,
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [(1<<BLK_W)-1:0] lock_bits,
  output rmode_t            mode,
  output logic [7:0]        status,
  output logic              running,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic              arr_lset,
  output logic              arr_lclr,
  output logic [ADDR_W-1:0] p_addr,
  output logic [7:0]        p_data,
  output logic [BLK_W-1:0]  e_blk
);
  pend_t      pend;
  ekind_t     ekind;
  logic       erase_run, erase_act, prog_run, prog_act;
  logic [6:0] sflags;
  logic       e_done, p_done, e_locked, p_locked;

  fci_timer #(.LIMIT(ERASE_CYC)) u_etmr (.clk(clk), .rst_n(rst_n),
    .clr(!rp_n || !erase_act), .run(erase_run), .done(e_done));
  fci_timer #(.LIMIT(PROG_CYC)) u_ptmr (.clk(clk), .rst_n(rst_n),
    .clr(!rp_n || !prog_act), .run(prog_run), .done(p_done));

  assign running  = erase_run || prog_run;
  assign status   = {!running, sflags};
  assign e_locked = lock_bits[e_blk];
  assign p_locked = lock_bits[p_addr[ADDR_W-1 -: BLK_W]];
  assign arr_prog  = rp_n && p_done && vpp_ok && !p_locked;
  assign arr_erase = rp_n && e_done && vpp_ok && ekind == EK_ERASE && !e_locked;
  assign arr_lset  = rp_n && e_done && vpp_ok && ekind == EK_LOCKSET;
  assign arr_lclr  = rp_n && e_done && vpp_ok && ekind == EK_LOCKCLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= RM_ARRAY; pend <= PD_NONE; ekind <= EK_ERASE; sflags <= '0;
      erase_run <= 1'b0; erase_act <= 1'b0; prog_run <= 1'b0; prog_act <= 1'b0;
      p_addr <= '0; p_data <= '0; e_blk <= '0;
    end else if (!rp_n) begin
      mode <= RM_ARRAY; pend <= PD_NONE; sflags <= '0;
      erase_run <= 1'b0; erase_act <= 1'b0; prog_run <= 1'b0; prog_act <= 1'b0;
    end else begin
      if (e_done) begin
        erase_run <= 1'b0; erase_act <= 1'b0;
        if (!vpp_ok) begin
          sflags[3] <= 1'b1; sflags[5] <= 1'b1;
          if (ekind != EK_ERASE) sflags[4] <= 1'b1;
        end else if (ekind == EK_ERASE && e_locked) begin
          sflags[5] <= 1'b1; sflags[1] <= 1'b1;
        end
      end
      if (p_done) begin
        prog_run <= 1'b0; prog_act <= 1'b0;
        if (!vpp_ok) begin
          sflags[3] <= 1'b1; sflags[4] <= 1'b1;
        end else if (p_locked) begin
          sflags[4] <= 1'b1; sflags[1] <= 1'b1;
        end
      end
      if (wr) begin
        case (pend)
          PD_ERASE: begin
            pend <= PD_NONE;
            if (wdata == C_CONFIRM) begin
              erase_run <= 1'b1; erase_act <= 1'b1; ekind <= EK_ERASE;
              e_blk <= waddr[ADDR_W-1 -: BLK_W];
            end else begin
              sflags[5] <= 1'b1; sflags[4] <= 1'b1;
            end
          end
          PD_LOCK: begin
            pend <= PD_NONE;
            if (wdata == C_LOCKSET || wdata == C_CONFIRM) begin
              erase_run <= 1'b1; erase_act <= 1'b1;
              ekind <= (wdata == C_LOCKSET) ? EK_LOCKSET : EK_LOCKCLR;
              e_blk <= waddr[ADDR_W-1 -: BLK_W];
            end else begin
              sflags[5] <= 1'b1; sflags[4] <= 1'b1;
            end
          end
          PD_PROG: begin
            pend <= PD_NONE; prog_run <= 1'b1; prog_act <= 1'b1;
            p_addr <= waddr; p_data <= wdata;
          end
          default: begin
            if (wdata == C_STATUS) mode <= RM_STATUS;
            else if (wdata == C_SUSP) begin
              if (prog_run && !p_done) begin
                prog_run <= 1'b0; sflags[2] <= 1'b1; mode <= RM_STATUS;
              end else if (erase_run && !e_done && ekind == EK_ERASE) begin
                erase_run <= 1'b0; sflags[6] <= 1'b1; mode <= RM_STATUS;
              end
            end else if (!running) begin
              case (wdata)
                C_ARRAY: mode <= RM_ARRAY;
                C_IDENT: mode <= RM_IDENT;
                C_QUERY: mode <= RM_QUERY;
                C_CLEAR: begin
                  sflags[5] <= 1'b0; sflags[4] <= 1'b0;
                  sflags[3] <= 1'b0; sflags[1] <= 1'b0;
                end
                C_ERASE: if (!erase_act) begin pend <= PD_ERASE; mode <= RM_STATUS; end
                C_LOCK:  if (!erase_act) begin pend <= PD_LOCK;  mode <= RM_STATUS; end
                C_PROG:  if (!prog_act)  begin pend <= PD_PROG;  mode <= RM_STATUS; end
                C_CONFIRM: begin
                  if (prog_act) begin
                    prog_run <= 1'b1; sflags[2] <= 1'b0; mode <= RM_STATUS;
                  end else if (erase_act) begin
                    erase_run <= 1'b1; sflags[6] <= 1'b0; mode <= RM_STATUS;
                  end
                end
                default: ;
              endcase
            end
          end
        endcase
      end
    end
  end

  // R1: the reset/power-down input returns the controller to its start state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_n |=> (status == 8'h80 && mode == RM_ARRAY));
  // R8: a wrong erase confirm reports both error bits in status mode
  a_r8_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pend == PD_ERASE && wdata != C_CONFIRM) |=>
      (status[5:4] == 2'b11 && mode == RM_STATUS && !erase_run));
  // R11: suspending an erase makes the device ready at once
  a_r11_erase_susp: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && pend == PD_NONE && wdata == C_SUSP && erase_run && !e_done &&
     ekind == EK_ERASE) |=> (!erase_run && status[7] && status[6]));
  // R12: program and erase never run together
  a_r12_single_run: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_run && prog_run));
  // R13: a running program continues unless suspended or reset
  a_r13_continue: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_n && prog_run && !p_done && !(wr && wdata == C_SUSP)) |=> prog_run);
endmodule

// File: rtl/fci_top.sv
module fci_top
  import fci_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BLK_W     = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 24,
  parameter logic [7:0] MFR_ID = 8'hA5,
  parameter logic [7:0] DEV_ID = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rp_n,
  input  logic              vpp_ok,
  input  logic              ce0_n,
  input  logic              ce1_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        dq_out,
  output logic              dq_en,
  output logic              ready
);
  localparam int NBLK = 1 << BLK_W;

  rmode_t            mode;
  logic [7:0]        status, arr_q, rd_val, p_data;
  logic [NBLK-1:0]   lock_bits;
  logic [ADDR_W-1:0] p_addr;
  logic [BLK_W-1:0]  e_blk;
  logic              wr, running, arr_prog, arr_erase, arr_lset, arr_lclr;

  assign wr = rp_n && !ce0_n && !ce1_n && !we_n;

  fci_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC),
             .ERASE_CYC(ERASE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_ok(vpp_ok), .wr(wr),
    .waddr(addr), .wdata(wdata), .lock_bits(lock_bits), .mode(mode),
    .status(status), .running(running), .arr_prog(arr_prog),
    .arr_erase(arr_erase), .arr_lset(arr_lset), .arr_lclr(arr_lclr),
    .p_addr(p_addr), .p_data(p_data), .e_blk(e_blk));

  fci_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog_en(arr_prog), .prog_addr(p_addr),
    .prog_data(p_data), .erase_en(arr_erase), .lock_set(arr_lset),
    .lock_clr(arr_lclr), .op_blk(e_blk), .rd_addr(addr), .rd_data(arr_q),
    .lock_bits(lock_bits));

  always_comb begin
    rd_val = '0;
    case (mode)
      RM_ARRAY:  rd_val = arr_q;
      RM_STATUS: rd_val = status;
      RM_IDENT:
        case (addr[1:0])
          2'd0: rd_val = MFR_ID;
          2'd1: rd_val = DEV_ID;
          2'd2: rd_val = {7'd0, lock_bits[addr[ADDR_W-1 -: BLK_W]]};
          default: rd_val = '0;
        endcase
      default:
        case (addr[1:0])
          2'd0: rd_val = 8'h51;
          2'd1: rd_val = 8'h52;
          2'd2: rd_val = 8'h59;
          default: rd_val = '0;
        endcase
    endcase
  end

  assign dq_en  = rp_n && !ce0_n && !ce1_n && !oe_n && we_n;
  assign dq_out = dq_en ? rd_val : '0;
  assign ready  = rp_n && !running;

  // R9: the array and lock bits change only with a valid programming voltage
  a_r9_vpp_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_prog || arr_erase || arr_lset || arr_lclr) |-> (vpp_ok && rp_n));
endmodule

// File: tb/fci_top_test.sv
module fci_top_test;
  localparam int AW = 6, BW = 2, PC = 8, EC = 24;
  logic clk = 0, rst_n = 0, rp_n = 1, vpp_ok = 1;
  logic ce0_n = 1, ce1_n = 1, oe_n = 1, we_n = 1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, dq_out;
  logic dq_en, ready;
  logic [7:0] mdl [64];
  int checks = 0, errs = 0;
  bit done = 0;

  fci_top #(.ADDR_W(AW), .BLK_W(BW), .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rst_n(rst_n), .rp_n(rp_n), .vpp_ok(vpp_ok), .ce0_n(ce0_n),
    .ce1_n(ce1_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .wdata(wdata),
    .dq_out(dq_out), .dq_en(dq_en), .ready(ready));

  always #4 clk = ~clk;

  function automatic logic [7:0] f_prog(input logic [7:0] old, input logic [7:0] d);
    return old & d;
  endfunction
  function automatic logic [7:0] f_query(input logic [1:0] off);
    case (off) 2'd0: return 8'h51; 2'd1: return 8'h52; 2'd2: return 8'h59; default: return 8'h00; endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin errs++; $display("FAIL %s: got %h expected %h", tag, act, exp); end
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    ce0_n = 0; ce1_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce0_n = 1; ce1_n = 1; we_n = 1;
  endtask
  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    ce0_n = 0; ce1_n = 0; oe_n = 0; addr = a; #1 v = dq_out;
    @(negedge clk); ce0_n = 1; ce1_n = 1; oe_n = 1;
  endtask
  task automatic busy_check(input string tag, input int cyc);
    chk({tag, " ready low at start"}, {7'd0, ready}, 8'h00);
    repeat (cyc - 1) @(negedge clk);
    chk({tag, " ready low at end"}, {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk({tag, " ready high after"}, {7'd0, ready}, 8'h01);
  endtask
  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(a, 8'h40); wr(a, d); busy_check("R6 program", PC);
  endtask
  task automatic erase(input logic [AW-1:0] a);
    wr(a, 8'h20); wr(a, 8'hD0); busy_check("R7 erase", EC);
  endtask
  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 ready after reset", {7'd0, ready}, 8'h01);
    wr(0, 8'h70); rd(0, v); chk("R1 status after reset", v, 8'h80);
    // R2 output enable
    ce0_n = 0; ce1_n = 1; oe_n = 0; #1 chk("R2 ce1 high no drive", {7'd0, dq_en}, 8'h00);
    ce0_n = 1; ce1_n = 0; #1 chk("R2 ce0 high no drive", {7'd0, dq_en}, 8'h00);
    ce0_n = 0; oe_n = 1; #1 chk("R2 oe high no drive", {7'd0, dq_en}, 8'h00);
    oe_n = 0; #1 chk("R2 all active drives", {7'd0, dq_en}, 8'h01);
    ce0_n = 1; ce1_n = 1; oe_n = 1; @(negedge clk);
    // R7 erase all blocks
    for (int b = 0; b < 4; b++) begin
      erase(AW'(b * 16));
      for (int i = 0; i < 16; i++) mdl[b * 16 + i] = 8'hFF;
    end
    // R4 identifier and query, also with vpp low
    vpp_ok = 0;
    wr(0, 8'h90);
    rd(0, v); chk("R4 manufacturer id", v, 8'hA5);
    rd(1, v); chk("R4 device id", v, 8'h3C);
    rd(2, v); chk("R4 lock bit clear", v, 8'h00);
    wr(0, 8'h98);
    for (int i = 0; i < 4; i++) begin rd(AW'(i), v); chk("R4 query", v, f_query(2'(i))); end
    vpp_ok = 1;
    // R6 random programming, R3 array reads
    for (int k = 0; k < 24; k++) begin
      logic [AW-1:0] a; logic [7:0] d;
      a = AW'($urandom() % 64); d = 8'($urandom());
      prog(a, d); mdl[a] = f_prog(mdl[a], d);
      if (k % 6 == 0) begin rd(a, v); chk("R5 status after program", v, 8'h80); end
    end
    wr(0, 8'hFF);
    for (int i = 0; i < 64; i++) begin rd(AW'(i), v); chk("R3 array readback", v, mdl[i]); end
    // R8 wrong erase confirm
    wr(6'h10, 8'h20); wr(6'h10, 8'h33);
    chk("R8 no busy", {7'd0, ready}, 8'h01);
    rd(0, v); chk("R8 status errors", v, 8'hB0);
    wr(0, 8'h50); rd(0, v); chk("R5 clear status", v, 8'h80);
    wr(0, 8'hFF); rd(6'h10, v); chk("R8 block untouched", v, mdl[16]);
    // R9 low programming voltage
    vpp_ok = 0;
    prog(6'h05, 8'h00); rd(0, v); chk("R9 program vpp error", v, 8'h98);
    wr(0, 8'h50); erase(6'h00); rd(0, v); chk("R9 erase vpp error", v, 8'hA8);
    wr(0, 8'h50); vpp_ok = 1;
    wr(0, 8'hFF); rd(6'h05, v); chk("R9 content kept", v, mdl[5]);
    // R10 lock bits
    wr(6'h30, 8'h60); wr(6'h30, 8'h01); busy_check("R10 lock set", EC);
    wr(0, 8'h90); rd(6'h32, v); chk("R10 block3 locked", v, 8'h01);
    rd(6'h02, v); chk("R10 block0 unlocked", v, 8'h00);
    prog(6'h31, 8'h00); rd(0, v); chk("R10 locked program", v, 8'h92);
    wr(0, 8'h50); erase(6'h33); rd(0, v); chk("R10 locked erase", v, 8'hA2);
    wr(0, 8'h50); wr(0, 8'hFF); rd(6'h31, v); chk("R10 locked content", v, mdl[49]);
    wr(0, 8'h60); wr(0, 8'hD0); busy_check("R10 lock clear", EC);
    wr(0, 8'h90); rd(6'h32, v); chk("R10 lock cleared", v, 8'h00);
    // R13 writes ignored while busy, deselected operation continues
    wr(6'h07, 8'h40); wr(6'h07, 8'h5A); mdl[7] = f_prog(mdl[7], 8'h5A);
    wr(0, 8'hFF); wr(0, 8'h90);
    wait_ready(n); chk("R13 completes on time", 8'(n), 8'(PC - 2));
    rd(0, v); chk("R13 mode still status", v, 8'h80);
    wr(0, 8'hFF); rd(6'h07, v); chk("R13 program result", v, mdl[7]);
    // R11 / R12 suspend nesting
    wr(6'h10, 8'h20); wr(6'h10, 8'hD0);
    repeat (5) @(negedge clk);
    wr(0, 8'hB0); chk("R11 ready after suspend", {7'd0, ready}, 8'h01);
    rd(0, v); chk("R11 erase suspended status", v, 8'hC0);
    wr(0, 8'hFF); rd(6'h10, v); chk("R11 read during suspend", v, mdl[16]);
    wr(6'h21, 8'h40); wr(6'h21, 8'h0F);
    repeat (2) @(negedge clk);
    wr(0, 8'hB0); chk("R12 ready after suspend", {7'd0, ready}, 8'h01);
    rd(0, v); chk("R12 both suspended", v, 8'hC4);
    wr(0, 8'hFF); rd(6'h21, v); chk("R12 not yet programmed", v, mdl[33]);
    wr(0, 8'hD0); wait_ready(n); chk("R12 program resumes first", 8'(n), 8'(PC - 3));
    mdl[33] = f_prog(mdl[33], 8'h0F);
    rd(0, v); chk("R12 program done erase suspended", v, 8'hC0);
    wr(0, 8'hFF); rd(6'h21, v); chk("R11 program during erase suspend", v, mdl[33]);
    wr(0, 8'hD0); wait_ready(n); chk("R11 erase remaining cycles", 8'(n), 8'(EC - 6));
    for (int i = 16; i < 32; i++) mdl[i] = 8'hFF;
    rd(0, v); chk("R11 status after resume", v, 8'h80);
    wr(0, 8'hFF);
    for (int i = 16; i < 32; i += 5) begin rd(AW'(i), v); chk("R11 block erased", v, mdl[i]); end
    // R1 abort on reset/power-down
    erase(6'h00); for (int i = 0; i < 16; i++) mdl[i] = 8'hFF;
    wr(6'h08, 8'h40); wr(6'h08, 8'h00);
    repeat (2) @(negedge clk);
    rp_n = 0; @(negedge clk);
    chk("R1 ready low in reset", {7'd0, ready}, 8'h00);
    ce0_n = 0; ce1_n = 0; oe_n = 0; #1 chk("R1 outputs off in reset", {7'd0, dq_en}, 8'h00);
    ce0_n = 1; ce1_n = 1; oe_n = 1;
    wr(6'h09, 8'h40); @(negedge clk);
    rp_n = 1; @(negedge clk);
    chk("R1 ready after release", {7'd0, ready}, 8'h01);
    rd(6'h08, v); chk("R1 aborted program no change", v, mdl[8]);
    wr(6'h09, 8'h00); rd(6'h09, v); chk("R1 write in reset ignored", v, mdl[9]);
    wr(0, 8'h70); rd(0, v); chk("R1 status after release", v, 8'h80);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule